// File: doc/BRIEF.md
# Timer Trigger Output Selector

This block belongs to a general-purpose timer. It takes the timer's internal events and turns them into one trigger output. Slave timers or an ADC use that output to stay in step with this timer. A 3-bit mode field in a 32-bit control word chooses the event that drives the trigger. The same word holds two more fields. One chooses when the per-channel capture/compare DMA requests are raised. The other chooses how the conditioned first timer input is formed: from the channel-1 pin alone, or from the exclusive-OR of the first three channel pins.

The counter, the compare units and the slave-mode controller lie outside this block. Their signals arrive as input ports. Every output is registered, so each one appears one clock after the cycle in which its source was present. The single exception is the slave-reset path in mode 0, which has one extra stage.

Top module: `trig_out_sel`

## Requirements
- R1: The control word resets to zero. A write through `reg_wr_en`/`reg_wdata` takes effect at the same clock edge. `reg_rdata` returns the stored fields in place and reads zero on every other bit, so writing all ones reads back 0x000000F8. The field positions are: bit 3 DMA timing, bits 6:4 trigger mode, bit 7 input select.
- R2: In mode 0, a one-cycle `ev_swupd` pulse gives a one-cycle `trig_out` pulse in the following cycle.
- R3: In mode 0, a one-cycle `ev_slv_rst` pulse (a counter reset caused by the trigger input) gives a one-cycle `trig_out` pulse two cycles later, one cycle after a software pulse would appear.
- R4: In mode 1, `trig_out` follows the counter enable one cycle later. The counter enable is `cnt_en_bit` when `gated_mode` is 0, and `cnt_en_bit AND trig_in` when `gated_mode` is 1.
- R5: In mode 2, `trig_out` copies the `ev_update` pulse one cycle later.
- R6: In mode 3, every cycle in which `cc_event[0]` is high gives a high `trig_out` cycle one cycle later. Back-to-back events (flag already set) give back-to-back pulses. Events on the other channels have no effect.
- R7: In modes 4, 5, 6 and 7, `trig_out` follows `oc_ref[0]`, `oc_ref[1]`, `oc_ref[2]` and `oc_ref[3]` respectively, one cycle later. The other references have no effect.
- R8: A change of mode applies from the cycle after the write. A change of mode never creates a pulse that the newly selected source does not call for.
- R9: With bit 3 at 0, `dma_req[i]` is high for one cycle after each `cc_event[i]`, and `ev_update` has no effect on `dma_req`.
- R10: With bit 3 at 1, every bit of `dma_req` is high for one cycle after each `ev_update`, and `cc_event` has no effect on `dma_req`.
- R11: With bit 7 at 0, `tin1` follows `ch_pin[0]` one cycle later. With bit 7 at 1, `tin1` follows `ch_pin[0] ^ ch_pin[1] ^ ch_pin[2]` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| ev_swupd | input | 1 | Software update-generation pulse |
| ev_slv_rst | input | 1 | Counter reset caused by the trigger input |
| ev_update | input | 1 | Update event pulse |
| cnt_en_bit | input | 1 | Counter-enable control bit |
| gated_mode | input | 1 | Slave controller is in gated mode |
| trig_in | input | 1 | Trigger input level |
| cc_event | input | 4 | Per-channel capture/compare flag-set events |
| oc_ref | input | 4 | Per-channel compare reference levels |
| ch_pin | input | 3 | Channel 1 to 3 input pins |
| trig_out | output | 1 | Trigger output to slaves |
| dma_req | output | 4 | Per-channel DMA request pulses |
| tin1 | output | 1 | Conditioned first timer input |

## Verification
The bench drives channel-1 events on two consecutive cycles. A design that suppressed re-triggering while the flag is still set would drop the second pulse. It checks that a slave-caused reset reaches the trigger exactly one cycle later than a software pulse; a design sharing one stage would show it early. It also switches the mode from a high counter-enable source to a low compare reference, where a design that did not update the source cleanly would show a glitch. It then swaps the DMA timing and input-select fields, so a design with inverted or misplaced field decoding routes the wrong event to the outputs.

// File: rtl/tos_pkg.sv
package tos_pkg;

    localparam int CTRL_W      = 32;
    localparam int DMA_SEL_BIT = 3;
    localparam int MODE_LSB    = 4;
    localparam int MODE_W      = 3;
    localparam int TIN_SEL_BIT = 7;

    localparam logic [CTRL_W-1:0] CTRL_MASK =
        (CTRL_W'(1) << DMA_SEL_BIT) |
        (CTRL_W'((1 << MODE_W) - 1) << MODE_LSB) |
        (CTRL_W'(1) << TIN_SEL_BIT);

    // Trigger source encoding; the numeric values are decoded by slaves' software.
    typedef enum logic [MODE_W-1:0] {
        TRG_SWUPD   = 3'd0,
        TRG_CNTEN   = 3'd1,
        TRG_UPDATE  = 3'd2,
        TRG_CC1PULS = 3'd3,
        TRG_REF1    = 3'd4,
        TRG_REF2    = 3'd5,
        TRG_REF3    = 3'd6,
        TRG_REF4    = 3'd7
    } trg_mode_e;

    typedef struct packed {
        logic      tin_xor;
        trg_mode_e mode;
        logic      dma_on_upd;
    } ctrl_t;

endpackage

// File: rtl/tos_ctrl_reg.sv
module tos_ctrl_reg
    import tos_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rdata
);

    typedef struct packed {
        ctrl_t ctrl;
    } state_t;

    state_t st_d, st_q;
    logic   unused_wbits;

    assign unused_wbits = ^(wdata & ~CTRL_MASK);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl.dma_on_upd = wdata[DMA_SEL_BIT];
            st_d.ctrl.mode       = trg_mode_e'(wdata[MODE_LSB +: MODE_W]);
            st_d.ctrl.tin_xor    = wdata[TIN_SEL_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata                         = '0;
        rdata[DMA_SEL_BIT]            = st_q.ctrl.dma_on_upd;
        rdata[MODE_LSB +: MODE_W]     = st_q.ctrl.mode;
        rdata[TIN_SEL_BIT]            = st_q.ctrl.tin_xor;
    end

    assign ctrl = st_q.ctrl;

endmodule

// File: rtl/tos_trig_mux.sv
module tos_trig_mux
    import tos_pkg::*;
#(
    parameter int NUM_REF = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  trg_mode_e          mode,
    input  logic               ev_swupd,
    input  logic               ev_slv_rst,
    input  logic               ev_update,
    input  logic               cnt_en_bit,
    input  logic               gated_mode,
    input  logic               trig_in,
    input  logic               cc1_evt,
    input  logic [NUM_REF-1:0] oc_ref,
    output logic               trig_out
);

    localparam int REF_IDX_W = (NUM_REF > 1) ? $clog2(NUM_REF) : 1;

    typedef struct packed {
        logic trig;
        logic slv_dly;
    } state_t;

    state_t            st_d, st_q;
    logic              cnt_en;
    logic [MODE_W-1:0] ref_ofs;
    logic [REF_IDX_W-1:0] ref_idx;

    // Counter enable as seen by the slaves: gated by the trigger input in gated mode.
    assign cnt_en  = cnt_en_bit & (trig_in | ~gated_mode);
    assign ref_ofs = MODE_W'(mode) - MODE_W'(TRG_REF1);
    assign ref_idx = ref_ofs[REF_IDX_W-1:0];

    always_comb begin
        st_d         = st_q;
        // The slave-triggered reset is seen one stage later than a software pulse.
        st_d.slv_dly = ev_slv_rst;
        unique case (mode)
            TRG_SWUPD:   st_d.trig = ev_swupd | st_q.slv_dly;
            TRG_CNTEN:   st_d.trig = cnt_en;
            TRG_UPDATE:  st_d.trig = ev_update;
            TRG_CC1PULS: st_d.trig = cc1_evt;
            default:     st_d.trig = oc_ref[ref_idx];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_out = st_q.trig;

endmodule

// File: rtl/tos_dma_route.sv
module tos_dma_route #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on_update,
    input  logic              ev_update,
    input  logic [NUM_CH-1:0] cc_event,
    output logic [NUM_CH-1:0] dma_req
);

    typedef struct packed {
        logic [NUM_CH-1:0] req;
    } state_t;

    state_t st_d, st_q;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_comb begin
            st_d.req[ch] = on_update ? ev_update : cc_event[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dma_req = st_q.req;

endmodule

// File: rtl/tos_tin_cond.sv
module tos_tin_cond #(
    parameter int NUM_XOR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               use_xor,
    input  logic [NUM_XOR-1:0] pins,
    output logic               tin
);

    typedef struct packed {
        logic tin;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tin = use_xor ? ^pins : pins[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tin = st_q.tin;

endmodule

// File: rtl/trig_out_sel.sv
module trig_out_sel
    import tos_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_XOR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic [CTRL_W-1:0]  reg_wdata,
    output logic [CTRL_W-1:0]  reg_rdata,
    input  logic               ev_swupd,
    input  logic               ev_slv_rst,
    input  logic               ev_update,
    input  logic               cnt_en_bit,
    input  logic               gated_mode,
    input  logic               trig_in,
    input  logic [NUM_CH-1:0]  cc_event,
    input  logic [NUM_CH-1:0]  oc_ref,
    input  logic [NUM_XOR-1:0] ch_pin,
    output logic               trig_out,
    output logic [NUM_CH-1:0]  dma_req,
    output logic               tin1
);

    ctrl_t ctrl;

    tos_ctrl_reg i_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .ctrl  (ctrl),
        .rdata (reg_rdata)
    );

    tos_trig_mux #(.NUM_REF(NUM_CH)) i_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (ctrl.mode),
        .ev_swupd   (ev_swupd),
        .ev_slv_rst (ev_slv_rst),
        .ev_update  (ev_update),
        .cnt_en_bit (cnt_en_bit),
        .gated_mode (gated_mode),
        .trig_in    (trig_in),
        .cc1_evt    (cc_event[0]),
        .oc_ref     (oc_ref),
        .trig_out   (trig_out)
    );

    tos_dma_route #(.NUM_CH(NUM_CH)) i_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .on_update (ctrl.dma_on_upd),
        .ev_update (ev_update),
        .cc_event  (cc_event),
        .dma_req   (dma_req)
    );

    tos_tin_cond #(.NUM_XOR(NUM_XOR)) i_tin (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_xor (ctrl.tin_xor),
        .pins    (ch_pin),
        .tin     (tin1)
    );

endmodule

// File: rtl/tos_chk.sv
module tos_chk
    import tos_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int NUM_XOR = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CTRL_W-1:0]  reg_rdata,
    input logic               ev_update,
    input logic               cnt_en_bit,
    input logic               gated_mode,
    input logic               trig_in,
    input logic [NUM_CH-1:0]  cc_event,
    input logic [NUM_XOR-1:0] ch_pin,
    input logic               trig_out,
    input logic [NUM_CH-1:0]  dma_req,
    input logic               tin1
);

    logic [MODE_W-1:0] mode_rd;
    assign mode_rd = reg_rdata[MODE_LSB +: MODE_W];

    // R1
    rdata_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~CTRL_MASK) == '0);

    // R4
    cnten_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 3'd1) |=> trig_out == $past(cnt_en_bit & (trig_in | ~gated_mode)));

    // R5
    update_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 3'd2) |=> trig_out == $past(ev_update));

    // R6
    cc1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == 3'd3) |=> trig_out == $past(cc_event[0]));

    // R9
    dma_on_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[DMA_SEL_BIT] |=> dma_req == $past(cc_event));

    // R10
    dma_on_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DMA_SEL_BIT] |=> dma_req == {NUM_CH{$past(ev_update)}});

    // R11
    tin_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[TIN_SEL_BIT] |=> tin1 == $past(^ch_pin));

    // R11
    tin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[TIN_SEL_BIT] |=> tin1 == $past(ch_pin[0]));

endmodule

bind trig_out_sel tos_chk #(.NUM_CH(NUM_CH), .NUM_XOR(NUM_XOR)) i_tos_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rdata  (reg_rdata),
    .ev_update  (ev_update),
    .cnt_en_bit (cnt_en_bit),
    .gated_mode (gated_mode),
    .trig_in    (trig_in),
    .cc_event   (cc_event),
    .ch_pin     (ch_pin),
    .trig_out   (trig_out),
    .dma_req    (dma_req),
    .tin1       (tin1)
);

// File: tb/test_trig_out_sel.sv
module test_trig_out_sel;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 4;
    localparam int NUM_XOR    = 3;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               reg_wr_en;
    logic [31:0]        reg_wdata;
    logic [31:0]        reg_rdata;
    logic               ev_swupd, ev_slv_rst, ev_update;
    logic               cnt_en_bit, gated_mode, trig_in;
    logic [NUM_CH-1:0]  cc_event, oc_ref;
    logic [NUM_XOR-1:0] ch_pin;
    logic               trig_out;
    logic [NUM_CH-1:0]  dma_req;
    logic               tin1;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_out_sel #(.NUM_CH(NUM_CH), .NUM_XOR(NUM_XOR)) i_trig_out_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ev_swupd   (ev_swupd),
        .ev_slv_rst (ev_slv_rst),
        .ev_update  (ev_update),
        .cnt_en_bit (cnt_en_bit),
        .gated_mode (gated_mode),
        .trig_in    (trig_in),
        .cc_event   (cc_event),
        .oc_ref     (oc_ref),
        .ch_pin     (ch_pin),
        .trig_out   (trig_out),
        .dma_req    (dma_req),
        .tin1       (tin1)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [31:0] val);
        reg_wr_en = 1'b1;
        reg_wdata = val;
        tick();
        reg_wr_en = 1'b0;
        reg_wdata = '0;
    endtask

    function automatic logic [31:0] ctrl_word(input logic tsel, input logic [2:0] mode,
                                              input logic dsel);
        return {24'd0, tsel, mode, dsel, 3'd0};
    endfunction

    task automatic idle_inputs();
        ev_swupd = 0; ev_slv_rst = 0; ev_update = 0;
        cnt_en_bit = 0; gated_mode = 0; trig_in = 0;
        cc_event = '0; oc_ref = '0; ch_pin = '0;
    endtask

    task automatic t_reset();
        check("R1", "reset rdata", reg_rdata, 32'h0);
        check("R1", "reset trig_out", {31'd0, trig_out}, 32'h0);
        check("R1", "reset dma_req", {28'd0, dma_req}, 32'h0);
        check("R1", "reset tin1", {31'd0, tin1}, 32'h0);
    endtask

    task automatic t_regmask();
        write_ctrl(32'hFFFF_FFFF);
        check("R1", "read masked", reg_rdata, 32'h0000_00F8);
        write_ctrl(32'h0000_0050);
        check("R1", "read mode5", reg_rdata, 32'h0000_0050);
    endtask

    task automatic t_mode0();
        write_ctrl(ctrl_word(0, 3'd0, 0));
        ev_swupd = 1; tick(); ev_swupd = 0;
        check("R2", "swupd pulse", {31'd0, trig_out}, 32'd1);
        tick();
        check("R2", "swupd end", {31'd0, trig_out}, 32'd0);
        ev_slv_rst = 1; tick(); ev_slv_rst = 0;
        check("R3", "slave reset early", {31'd0, trig_out}, 32'd0);
        tick();
        check("R3", "slave reset delayed", {31'd0, trig_out}, 32'd1);
        tick();
        check("R3", "slave reset end", {31'd0, trig_out}, 32'd0);
    endtask

    task automatic t_mode1();
        write_ctrl(ctrl_word(0, 3'd1, 0));
        cnt_en_bit = 1; gated_mode = 0; trig_in = 0; tick();
        check("R4", "free-running enable", {31'd0, trig_out}, 32'd1);
        gated_mode = 1; tick();
        check("R4", "gated, trig low", {31'd0, trig_out}, 32'd0);
        trig_in = 1; tick();
        check("R4", "gated, trig high", {31'd0, trig_out}, 32'd1);
        cnt_en_bit = 0; tick();
        check("R4", "bit off", {31'd0, trig_out}, 32'd0);
        gated_mode = 0; trig_in = 0;
    endtask

    task automatic t_mode2();
        write_ctrl(ctrl_word(0, 3'd2, 0));
        ev_update = 1; tick(); ev_update = 0;
        check("R5", "update pulse", {31'd0, trig_out}, 32'd1);
        tick();
        check("R5", "update end", {31'd0, trig_out}, 32'd0);
    endtask

    task automatic t_mode3();
        write_ctrl(ctrl_word(0, 3'd3, 0));
        cc_event = 4'b0001; tick();
        check("R6", "cc1 first", {31'd0, trig_out}, 32'd1);
        tick(); cc_event = 4'b0000;
        check("R6", "cc1 back-to-back", {31'd0, trig_out}, 32'd1);
        tick();
        check("R6", "cc1 end", {31'd0, trig_out}, 32'd0);
        cc_event = 4'b1110; tick(); cc_event = '0;
        check("R6", "other channels ignored", {31'd0, trig_out}, 32'd0);
    endtask

    task automatic t_refs();
        for (int m = 4; m < 8; m++) begin
            write_ctrl(ctrl_word(0, 3'(m), 0));
            oc_ref = 4'b1111 & ~(4'b0001 << (m - 4)); tick();
            check("R7", $sformatf("mode%0d others high", m), {31'd0, trig_out}, 32'd0);
            oc_ref = 4'b0001 << (m - 4); tick();
            check("R7", $sformatf("mode%0d own ref", m), {31'd0, trig_out}, 32'd1);
            oc_ref = '0; tick();
        end
    endtask

    task automatic t_switch();
        write_ctrl(ctrl_word(0, 3'd1, 0));
        cnt_en_bit = 1; oc_ref = '0; tick();
        check("R8", "enable high before switch", {31'd0, trig_out}, 32'd1);
        write_ctrl(ctrl_word(0, 3'd4, 0));
        check("R8", "old source at write edge", {31'd0, trig_out}, 32'd1);
        tick();
        check("R8", "new source low", {31'd0, trig_out}, 32'd0);
        tick();
        check("R8", "no pulse after switch", {31'd0, trig_out}, 32'd0);
        cnt_en_bit = 0;
        write_ctrl(ctrl_word(0, 3'd2, 0));
        tick();
        check("R8", "switch to update idle", {31'd0, trig_out}, 32'd0);
    endtask

    task automatic t_dma();
        write_ctrl(ctrl_word(0, 3'd0, 0));
        cc_event = 4'b0101; tick(); cc_event = '0;
        check("R9", "cc routed", {28'd0, dma_req}, 32'h5);
        ev_update = 1; tick(); ev_update = 0;
        check("R9", "update ignored", {28'd0, dma_req}, 32'h0);
        write_ctrl(ctrl_word(0, 3'd0, 1));
        ev_update = 1; tick(); ev_update = 0;
        check("R10", "update to all", {28'd0, dma_req}, 32'hF);
        cc_event = 4'b1010; tick(); cc_event = '0;
        check("R10", "cc ignored", {28'd0, dma_req}, 32'h0);
    endtask

    task automatic t_tin();
        write_ctrl(ctrl_word(0, 3'd0, 0));
        ch_pin = 3'b110; tick();
        check("R11", "single pin low", {31'd0, tin1}, 32'd0);
        ch_pin = 3'b001; tick();
        check("R11", "single pin high", {31'd0, tin1}, 32'd1);
        write_ctrl(ctrl_word(1, 3'd0, 0));
        ch_pin = 3'b110; tick();
        check("R11", "xor 110", {31'd0, tin1}, 32'd0);
        ch_pin = 3'b111; tick();
        check("R11", "xor 111", {31'd0, tin1}, 32'd1);
        ch_pin = 3'b100; tick();
        check("R11", "xor 100", {31'd0, tin1}, 32'd1);
        ch_pin = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; reg_wr_en = 0; reg_wdata = '0;
        idle_inputs();
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_regmask();
        t_mode0();
        t_mode1();
        t_mode2();
        t_mode3();
        t_refs();
        t_switch();
        t_dma();
        t_tin();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule